// File: doc/BRIEF.md
# Debounced Key Click Capture

This block turns a bouncing pushbutton into clean click events for a controller. A slow sampling clock drives a debouncer, which accepts a new key level only after the raw input has held that level for a set number of samples in a row. Each accepted press, meaning a rising edge of the filtered level, is carried into the fast system clock domain. There it sets a one-bit set/reset flag.

The controller on the fast clock watches the pending output. Once it has handled the click, it raises acknowledge for a cycle, which clears the flag. A press and an acknowledge that land in the same fast cycle resolve in favour of the press, so no click is dropped. Releasing the key and holding it down produce no further events.

Top module: `keyCapture`

## Requirements
- R1: While reset is low, the pending output is 0 and the filtered key level returns to "released". A key held down through reset is therefore seen as a fresh press once reset ends.
- R2: The filtered level changes only after the raw key has shown the new level on 4 consecutive slow-clock samples. A pulse or bounce that spans 3 or fewer samples produces no click.
- R3: Each accepted press raises the pending output exactly once. Holding the key down, even for many slow periods, sets the flag no more than once.
- R4: An accepted release (filtered level going 1 to 0) never sets the flag.
- R5: Once set, the pending output stays 1 until acknowledge is sampled high on a fast-clock edge. It then reads 0 after that edge, provided no new press arrives in the same cycle. Acknowledge while nothing is pending has no effect.
- R6: When acknowledge and a new press reach the flag in the same fast cycle, the flag is set.
- R7: The filtered press is passed through a two-stage synchronizer and an edge detector on the fast clock. With a fast clock 8 times the slow clock, the pending output rises between 30 and 48 fast cycles after the raw key settles high.
- R8: A second press while a click is still pending leaves one pending flag. It is not queued, and one acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slowClk | input | 1 | Low-frequency sampling clock for the debouncer |
| fastClk | input | 1 | High-frequency system clock of the controller |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| keyRaw | input | 1 | Raw pushbutton level, 1 = pressed, may bounce |
| ackIn | input | 1 | Acknowledge from the controller, fast domain |
| clickPending | output | 1 | 1 while an accepted click awaits acknowledge |

## Verification
Some properties are checked on every clock cycle. The filtered level may change only when the stability counter has reached its limit. The edge detector emits single-cycle strobes. A set strobe always leaves the flag high, even against acknowledge. The flag holds without acknowledge and falls after an acknowledge that has no competing set.

Other behaviour can only be shown by the bench's scenarios. These include rejection of bounce trains and short glitches, exactly one click per press over long holds, silence on release, the crossing latency, merging of a second press, and the key-held-through-reset case. The bench covers the press-and-acknowledge collision by holding acknowledge high across a press. It then expects the flag to be high for exactly one fast cycle.

// File: rtl/kc_pkg.sv
package kc_pkg;
  // Strobes from the fast-domain control to the flag datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } flagCmd_t;
endpackage

// File: rtl/kcDebounce.sv
module kcDebounce #(
  parameter int STABLE_COUNT = 4
) (
  input  logic slowClk,
  input  logic rstN,
  input  logic keyRaw,
  output logic keyLevel
);
  localparam int CNT_W = $clog2(STABLE_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_COUNT - 1);

  logic             rawQ;
  logic [CNT_W-1:0] stabCnt;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      rawQ     <= 1'b0;
      stabCnt  <= '0;
      keyLevel <= 1'b0;
    end else begin
      rawQ <= keyRaw;
      if (rawQ != keyLevel) begin
        if (stabCnt == CNT_LAST) begin
          keyLevel <= rawQ;
          stabCnt  <= '0;
        end else begin
          stabCnt <= stabCnt + 1'b1;
        end
      end else begin
        stabCnt <= '0;
      end
    end
  end

  // R2
  level_needs_full_count_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    (keyLevel != $past(keyLevel)) |-> ($past(stabCnt) == CNT_LAST));
endmodule

// File: rtl/kcCtrl.sv
module kcCtrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              fastClk,
  input  logic              rstN,
  input  logic              keyLevelAsync,
  input  logic              ackIn,
  output kc_pkg::flagCmd_t  cmd
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge fastClk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= keyLevelAsync;
        else syncQ[i] <= syncQ[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  always_comb begin
    cmd.setFlag = syncQ[SYNC_STAGES-1] & ~prevQ;
    cmd.clrFlag = ackIn;
  end

  // R3
  single_set_strobe_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    cmd.setFlag |=> !cmd.setFlag);
endmodule

// File: rtl/kcFlag.sv
module kcFlag (
  input  logic              fastClk,
  input  logic              rstN,
  input  kc_pkg::flagCmd_t  cmd,
  output logic              pending
);
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN)            pending <= 1'b0;
    else if (cmd.setFlag) pending <= 1'b1;
    else if (cmd.clrFlag) pending <= 1'b0;
  end

  // R6
  set_wins_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    cmd.setFlag |=> pending);
  // R5
  hold_until_ack_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    (pending && !cmd.clrFlag) |=> pending);
  // R5
  ack_clears_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    (cmd.clrFlag && !cmd.setFlag) |=> !pending);
endmodule

// File: rtl/keyCapture.sv
module keyCapture #(
  parameter int STABLE_COUNT = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic slowClk,
  input  logic fastClk,
  input  logic rstN,
  input  logic keyRaw,
  input  logic ackIn,
  output logic clickPending
);
  logic             keyLevel;
  kc_pkg::flagCmd_t cmd;

  kcDebounce #(.STABLE_COUNT(STABLE_COUNT)) u_deb (
    .slowClk(slowClk), .rstN(rstN), .keyRaw(keyRaw), .keyLevel(keyLevel));

  kcCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .fastClk(fastClk), .rstN(rstN), .keyLevelAsync(keyLevel),
    .ackIn(ackIn), .cmd(cmd));

  kcFlag u_flag (
    .fastClk(fastClk), .rstN(rstN), .cmd(cmd), .pending(clickPending));
endmodule

// File: tb/keyCapture_tb.sv
module keyCapture_tb;
  logic slowClk = 1'b0, fastClk = 1'b0, rstN = 1'b0;
  logic keyRaw = 1'b0, ackIn = 1'b0;
  logic clickPending;
  int nChecks = 0, nFail = 0, cycles = 0, pulseLen = 0;
  int expQ[$];
  int clickId = 0;
  logic prevPend = 1'b0;

  keyCapture u_dut (.slowClk(slowClk), .fastClk(fastClk), .rstN(rstN),
    .keyRaw(keyRaw), .ackIn(ackIn), .clickPending(clickPending));

  always #2.5 fastClk = ~fastClk;
  initial begin #2; forever #20 slowClk = ~slowClk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every rising edge of the pending output must match a queued click
  always @(negedge fastClk) begin
    cycles++;
    if (rstN) begin
      if (clickPending) pulseLen++;
      if (clickPending && !prevPend) begin
        pulseLen = 1;
        nChecks++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL R3: actual 1 unexpected pending rise expected 0");
        end else begin
          void'(expQ.pop_front());
        end
      end
    end
    prevPend = clickPending;
  end

  task automatic keyFor(input logic v, input int nFast);
    keyRaw = v;
    repeat (nFast) @(negedge fastClk);
  endtask

  task automatic bounce(input logic finalV);
    for (int i = 0; i < 3; i++) begin
      keyFor(finalV, 16);
      keyFor(!finalV, 16);
    end
  endtask

  // Returns fast cycles until pending, or -1
  task automatic waitPend(output int n);
    n = -1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge fastClk);
      if (clickPending) begin n = i; break; end
    end
  endtask

  task automatic ackPulse();
    ackIn = 1'b1;
    @(negedge fastClk);
    ackIn = 1'b0;
  endtask

  task automatic quiet(input string req, input int nFast);
    for (int i = 0; i < nFast; i++) begin
      @(negedge fastClk);
      if (clickPending) begin
        chk(1'b0, req, 1, 0);
        break;
      end
    end
    chk(!clickPending, req, int'(clickPending), 0);
  endtask

  // Driver: bounced press, expected click queued before the key settles
  task automatic press(output int lat);
    bounce(1'b1);
    clickId++;
    expQ.push_back(clickId);
    keyRaw = 1'b1;
    waitPend(lat);
  endtask

  task automatic release_key();
    bounce(1'b0);
    keyFor(1'b0, 80);
  endtask

  initial begin
    int lat;
    repeat (2) @(negedge fastClk);
    // R1
    chk(clickPending == 1'b0, "R1", int'(clickPending), 0);
    #83 rstN = 1'b1;
    @(negedge fastClk);
    chk(clickPending == 1'b0, "R1", int'(clickPending), 0);

    // R5: acknowledge while idle does nothing
    ackPulse();
    chk(clickPending == 1'b0, "R5", int'(clickPending), 0);

    // R7 latency and basic press
    press(lat);
    chk(lat >= 30 && lat <= 48, "R7", lat, 40);
    // R5: stays set without acknowledge
    repeat (100) @(negedge fastClk);
    chk(clickPending == 1'b1, "R5", int'(clickPending), 1);
    ackPulse();
    chk(clickPending == 1'b0, "R5", int'(clickPending), 0);
    // R3: long hold, no second click
    quiet("R3", 400);
    // R4: release with bounce sets nothing
    bounce(1'b0);
    keyRaw = 1'b0;
    quiet("R4", 120);

    // R2: short glitches of 3 samples and a bounce train, no click
    keyFor(1'b1, 24);
    keyFor(1'b0, 80);
    bounce(1'b1);
    keyFor(1'b0, 80);
    quiet("R2", 80);

    // R8: second press while pending merges
    press(lat);
    chk(lat > 0, "R8", lat, 40);
    release_key();
    bounce(1'b1);
    keyFor(1'b1, 120);
    chk(clickPending == 1'b1, "R8", int'(clickPending), 1);
    ackPulse();
    chk(clickPending == 1'b0, "R8", int'(clickPending), 0);
    quiet("R8", 100);
    release_key();

    // R6: acknowledge held high across a press; set wins for one cycle
    ackIn = 1'b1;
    pulseLen = 0;
    press(lat);
    chk(lat > 0, "R6", lat, 40);
    repeat (4) @(negedge fastClk);
    chk(pulseLen == 1, "R6", pulseLen, 1);
    chk(clickPending == 1'b0, "R6", int'(clickPending), 0);
    ackIn = 1'b0;
    release_key();

    // R1: key held through reset is a fresh press afterwards
    press(lat);
    keyFor(1'b1, 20);
    rstN = 1'b0;
    @(negedge fastClk);
    chk(clickPending == 1'b0, "R1", int'(clickPending), 0);
    prevPend = 1'b0;
    keyFor(1'b1, 10);
    clickId++;
    expQ.push_back(clickId);
    rstN = 1'b1;
    waitPend(lat);
    chk(lat > 0, "R1", lat, 40);
    ackPulse();
    release_key();

    repeat (20) @(negedge fastClk);
    chk(expQ.size() == 0, "R3", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule